// File: doc/BRIEF.md
# D-channel extension time-slice multiplexer

This block lets one single-channel HDLC engine serve eight digital extension lines. Each line carries a 16 kbps D-channel in both directions. The block connects exactly one extension to the engine at a time. It passes the receive bit of that extension to the engine and sends the engine's transmit bit back to that extension only. Every extension that is not selected sees a steady idle level of logic 1 on its transmit line.

The selection moves on a fixed schedule. A dwell timer counts 1 ms ticks, and after eight ticks a move to the next extension becomes pending. The move takes effect on the next 16 kbps bit strobe, so no bit is ever split between two extensions. The index rises in order and wraps from the last extension back to 0. One rotation therefore takes 64 ms, and each line gets an average of 2 kbps. A one-cycle change marker tells the engine to abort or close the frame it has in progress.

The serial lines are strobe-paced and have no valid/ready handshake. The bit strobe takes the place of valid. There is no back-pressure: the engine must take or give one bit on every strobe. The dwell tick, the strobe and the status outputs are plain level or pulse pins.

Top module: `dch_slice_mux`

## Requirements
- R1: While reset is asserted (rst_n low) and in the first cycle after it, `sel_idx` is 0, `sel_change` is 0, and every `ext_tx` bit except bit 0 is 1.
- R2: A move becomes pending on the DWELL_MS-th `tick_ms` pulse counted since reset or since the previous move became pending (DWELL_MS = 8). The tick count keeps running while a move is pending.
- R3: `sel_idx` changes only on the clock edge at which `bit_stb` is high and a move is already pending. A strobe in the same cycle as the tick that makes the move pending does not apply it.
- R4: On each move, `sel_idx` rises by one and wraps from NUM_EXT-1 (7) to 0.
- R5: `sel_change` is high for exactly the one cycle in which `sel_idx` first shows a new value, and is low at all other times.
- R6: `ctl_rx` always equals `ext_rx[sel_idx]`.
- R7: `ext_tx[sel_idx]` equals `ctl_tx`, and every other `ext_tx` bit is 1.
- R8: A pending move is held for as long as no strobe arrives. It is applied once, by the first strobe that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_ms | input | 1 | One-cycle pulse every 1 ms |
| bit_stb | input | 1 | One-cycle pulse at each 16 kbps bit boundary |
| ext_rx | input | 8 | Receive D-channel bit from each extension |
| ctl_tx | input | 1 | Transmit bit from the HDLC engine |
| ctl_rx | output | 1 | Receive bit passed to the HDLC engine |
| ext_tx | output | 8 | Transmit D-channel bit to each extension (1 when idle) |
| sel_idx | output | 3 | Index of the connected extension |
| sel_change | output | 1 | One-cycle marker when the selection moves |

## Verification
Random ticks and strobes at uneven rates, with random line data, test the routing and the schedule together against a cycle model. This separates a correct rotation from an off-by-one dwell or a wrong route. A directed run of eight ticks with no strobe, followed by a long silence, shows that a pending move is held and not dropped. A strobe that arrives in the same cycle as the eighth tick shows that the move is not applied early. A full rotation shows the wrap from 7 to 0 and checks that idle lines stay at 1.

// File: rtl/dch_pkg.sv
package dch_pkg;
  // Advance an index by one inside [0, lim-1], wrapping to zero.
  function automatic int unsigned wrap_inc(int unsigned v, int unsigned lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/dch_dwell_timer.sv
module dch_dwell_timer #(
  parameter int unsigned DWELL_MS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_ms,
  input  logic take,
  output logic pend
);
  localparam int unsigned CNT_W = (DWELL_MS > 1) ? $clog2(DWELL_MS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL_MS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;
  logic             wrap;

  assign wrap = tick_ms && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick_ms) begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

  // A new wrap wins over a take in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (wrap) begin
      pend_q <= 1'b1;
    end else if (take) begin
      pend_q <= 1'b0;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/dch_sel_ring.sv
module dch_sel_ring
  import dch_pkg::*;
#(
  parameter int unsigned NUM_EXT = 8,
  localparam int unsigned IDX_W = (NUM_EXT > 1) ? $clog2(NUM_EXT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pend,
  input  logic             bit_stb,
  output logic             take,
  output logic [IDX_W-1:0] idx,
  output logic             change
);
  logic [IDX_W-1:0] idx_q;
  logic             chg_q;

  assign take = pend && bit_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      chg_q <= 1'b0;
    end else begin
      chg_q <= take;
      if (take) begin
        idx_q <= IDX_W'(wrap_inc(int'(idx_q), NUM_EXT));
      end
    end
  end

  assign idx    = idx_q;
  assign change = chg_q;
endmodule

// File: rtl/dch_line_router.sv
module dch_line_router #(
  parameter int unsigned NUM_EXT = 8,
  localparam int unsigned IDX_W = (NUM_EXT > 1) ? $clog2(NUM_EXT) : 1
) (
  input  logic [IDX_W-1:0]   idx,
  input  logic [NUM_EXT-1:0] ext_rx,
  input  logic               ctl_tx,
  output logic               ctl_rx,
  output logic [NUM_EXT-1:0] ext_tx
);
  assign ctl_rx = ext_rx[idx];

  for (genvar g = 0; g < NUM_EXT; g++) begin : g_line
    // Unselected lines idle at logic 1.
    assign ext_tx[g] = (idx == IDX_W'(g)) ? ctl_tx : 1'b1;
  end
endmodule

// File: rtl/dch_slice_mux.sv
module dch_slice_mux #(
  parameter int unsigned NUM_EXT  = 8,
  parameter int unsigned DWELL_MS = 8,
  localparam int unsigned IDX_W = (NUM_EXT > 1) ? $clog2(NUM_EXT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_ms,
  input  logic               bit_stb,
  input  logic [NUM_EXT-1:0] ext_rx,
  input  logic               ctl_tx,
  output logic               ctl_rx,
  output logic [NUM_EXT-1:0] ext_tx,
  output logic [IDX_W-1:0]   sel_idx,
  output logic               sel_change
);
  logic pend;
  logic take;

  dch_dwell_timer #(.DWELL_MS(DWELL_MS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_ms (tick_ms),
    .take    (take),
    .pend    (pend)
  );

  dch_sel_ring #(.NUM_EXT(NUM_EXT)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend    (pend),
    .bit_stb (bit_stb),
    .take    (take),
    .idx     (sel_idx),
    .change  (sel_change)
  );

  dch_line_router #(.NUM_EXT(NUM_EXT)) u_router (
    .idx    (sel_idx),
    .ext_rx (ext_rx),
    .ctl_tx (ctl_tx),
    .ctl_rx (ctl_rx),
    .ext_tx (ext_tx)
  );
endmodule

// File: rtl/dch_slice_mux_chk.sv
module dch_slice_mux_chk #(
  parameter int unsigned NUM_EXT = 8,
  localparam int unsigned IDX_W = (NUM_EXT > 1) ? $clog2(NUM_EXT) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bit_stb,
  input logic [NUM_EXT-1:0] ext_rx,
  input logic               ctl_tx,
  input logic               ctl_rx,
  input logic [NUM_EXT-1:0] ext_tx,
  input logic [IDX_W-1:0]   sel_idx,
  input logic               sel_change
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(NUM_EXT - 1);

  // R3
  move_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_idx) |-> $past(bit_stb));

  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_idx) |-> sel_idx == (($past(sel_idx) == TOP) ? '0 : $past(sel_idx) + 1'b1));

  // R5
  marker_on_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_change |-> !$stable(sel_idx));

  // R5
  marker_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_idx) |-> sel_change);

  // R5
  marker_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_change |=> !sel_change);

  // R6
  rx_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rx == ext_rx[sel_idx]);

  // R7
  tx_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_tx[sel_idx] == ctl_tx && $countones(~ext_tx) <= 1);
endmodule

bind dch_slice_mux dch_slice_mux_chk #(.NUM_EXT(NUM_EXT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_stb    (bit_stb),
  .ext_rx     (ext_rx),
  .ctl_tx     (ctl_tx),
  .ctl_rx     (ctl_rx),
  .ext_tx     (ext_tx),
  .sel_idx    (sel_idx),
  .sel_change (sel_change)
);

// File: tb/dch_slice_mux_tb.sv
`timescale 1ns/1ps
module dch_slice_mux_tb;
  localparam int NE = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_ms = 1'b0;
  logic          bit_stb = 1'b0;
  logic [NE-1:0] ext_rx = '0;
  logic          ctl_tx = 1'b0;
  logic          ctl_rx;
  logic [NE-1:0] ext_tx;
  logic [2:0]    sel_idx;
  logic          sel_change;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Cycle model built from the requirements
  int m_cnt = 0, m_idx = 0;
  bit m_pend = 0, m_chg = 0;

  always #2 clk = ~clk;

  dch_slice_mux u_dut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .bit_stb(bit_stb),
    .ext_rx(ext_rx), .ctl_tx(ctl_tx), .ctl_rx(ctl_rx), .ext_tx(ext_tx),
    .sel_idx(sel_idx), .sel_change(sel_change)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= 0; m_pend <= 0; m_idx <= 0; m_chg <= 0;
    end else begin
      bit wrap, sw;
      wrap = tick_ms && (m_cnt == DW - 1);
      sw   = bit_stb && m_pend;
      if (tick_ms) m_cnt <= wrap ? 0 : m_cnt + 1;
      m_pend <= wrap ? 1'b1 : (sw ? 1'b0 : m_pend);
      if (sw) m_idx <= (m_idx == NE - 1) ? 0 : m_idx + 1;
      m_chg <= sw;
    end
  end

  function automatic logic [NE-1:0] exp_tx(int idx, logic tx);
    logic [NE-1:0] v = '1;
    v[idx] = tx;
    return v;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_cmp();
    chk("R3/R4 sel_idx vs model", int'(sel_idx), m_idx);
    chk("R5 sel_change vs model", int'(sel_change), int'(m_chg));
    chk("R6 ctl_rx route", int'(ctl_rx), int'(ext_rx[m_idx]));
    chk("R7 ext_tx route", int'(ext_tx), int'(exp_tx(m_idx, ctl_tx)));
  endtask

  // Drive one cycle of stimulus at a negedge and check at the following negedge.
  task automatic cyc(bit t, bit s);
    tick_ms = t;
    bit_stb = s;
    ext_rx  = NE'($urandom);
    ctl_tx  = 1'($urandom);
    @(negedge clk);
    model_cmp();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 reset sel_idx", int'(sel_idx), 0);
    chk("R1 reset sel_change", int'(sel_change), 0);
    chk("R1 reset idle lines", int'(ext_tx[NE-1:1]), (1 << (NE - 1)) - 1);
    rst_n = 1'b1;
    cyc(0, 0);
    chk("R1 after release sel_idx", int'(sel_idx), 0);

    // R2/R8: eight ticks, no strobe, pending move is held
    for (int k = 0; k < DW; k++) begin cyc(1, 0); cyc(0, 0); end
    repeat (30) cyc(0, 0);
    chk("R8 held without strobe", int'(sel_idx), 0);
    cyc(0, 1);
    chk("R2 move after strobe", int'(sel_idx), 1);
    chk("R5 marker high", int'(sel_change), 1);
    cyc(0, 1);
    chk("R5 marker one cycle", int'(sel_change), 0);
    chk("R8 applied once", int'(sel_idx), 1);

    // R3: strobe in the same cycle as the wrapping tick does not apply
    for (int k = 0; k < DW - 1; k++) cyc(1, 0);
    cyc(1, 1);
    chk("R3 same-cycle strobe ignored", int'(sel_idx), 1);
    cyc(0, 0);
    chk("R3 still held", int'(sel_idx), 1);
    cyc(0, 1);
    chk("R3 next strobe applies", int'(sel_idx), 2);

    // R4: complete the rotation and wrap to 0
    for (int r = 3; r <= NE; r++) begin
      for (int k = 0; k < DW; k++) cyc(1, 0);
      cyc(0, 1);
      chk("R4 ascending index", int'(sel_idx), r % NE);
    end
    chk("R4 wrap to zero", int'(sel_idx), 0);

    // Random traffic against the model
    for (int n = 0; n < 30000; n++)
      cyc(($urandom % 16) == 0, ($urandom % 4) == 0);

    finish_run();
  end
endmodule